// File: doc/BRIEF.md
# Programmable Logic Slice

This block models one slice of a RAM-configured programmable array. Two 16-entry truth tables and a few mode and bypass bits sit in one serial chain. The chain is loaded one bit per clock while the load enable is high. Once the chain is loaded, the slice can act in one of these ways:

- two independent 4-input functions;
- one 5-input function, where a fifth input picks between the tables;
- the last stage of a 6-input function, built with a neighbour slice through the cascade pins;
- a two-bit slice of a ripple adder;
- a small writable memory, organised as 16 words of 2 bits or as 32 words of 1 bit.

Each function output can be taken straight from the logic or through a register with a clock enable. The configuration cells are ordinary storage, so the slice can be reloaded at any time after reset. A wider adder is built by chaining `carryOut` of one slice to `carryIn` of the next.

Top module: `logic_slice`

## Requirements
- R1: While `cfgLoad` is high, each clock edge shifts `cfgBit` into a 37-bit chain. The first bit shifted ends up as table A entry 0, and the next bits fill table A entries 1 to 15 and then table B entries 0 to 15. They are followed by the mode code (3 bits, least significant bit first), then the bypass bit for `out0`, then the bypass bit for `out1`.
- R2: While `cfgLoad` is high, `out0`, `out1`, `cascadeOut` and `carryOut` are 0, both output registers are cleared, and memory writes have no effect.
- R3: With mode code 0, and also with the unused codes 6 and 7, the logic value of `out0` is entry `inA` of table A and the logic value of `out1` is entry `inB` of table B.
- R4: With mode code 1, the logic value of `out0` is table B entry `inA` when `sel5` is 1 and table A entry `inA` when `sel5` is 0, and `out1` is as in R3. In every mode outside loading, `cascadeOut` carries this merged value.
- R5: With mode code 2, the logic value of `out0` is `cascadeIn` when `sel6` is 1 and the merged value of R4 when `sel6` is 0. `out1` is as in R3.
- R6: With mode code 3, {`carryOut`,`out1`,`out0`} equals `inA[1:0]` + `inB[1:0]` + `carryIn`, and carry propagates combinationally. In every other mode `carryOut` is 0.
- R7: With mode code 4, a clock edge with `wrEn` high writes `wrData[0]` to table A and `wrData[1]` to table B, both at entry `wrAddr[3:0]`. The reads are combinational: `out0` is table A entry `inA` and `out1` is table B entry `inA`. A read of the address being written returns the old data until the edge.
- R8: With mode code 5, the two tables form one 32x1 memory. A write stores `wrData[0]` into table B when `wrAddr[4]` is 1 and into table A otherwise, at entry `wrAddr[3:0]`. The read returns address {`sel5`,`inA`} on `out0`, and `out1` is 0.
- R9: In mode codes 0 to 3, `wrEn` leaves both tables unchanged.
- R10: When an output's bypass bit is 1, the output shows its logic value in the same cycle. When the bit is 0, the output shows a register that captures the logic value on each edge with `regCe` high and holds it while `regCe` is low.
- R11: A synchronous `rst` clears the whole configuration (tables zero, mode 0, both outputs registered) and both output registers. A later load fully replaces the earlier configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration, memory writes and output registers |
| rst | input | 1 | Synchronous reset, active high |
| cfgLoad | input | 1 | Serial configuration shift enable |
| cfgBit | input | 1 | Serial configuration data |
| inA | input | 4 | Table A index, shared index for 5/6-input and memory reads, adder operand A |
| inB | input | 4 | Table B index, adder operand B |
| sel5 | input | 1 | Fifth function input, high read address bit in 32x1 memory |
| sel6 | input | 1 | Sixth function input, selects the cascade value |
| cascadeIn | input | 1 | Merged value from the neighbour slice |
| carryIn | input | 1 | Carry from the lower slice |
| wrEn | input | 1 | Memory write enable |
| wrAddr | input | 5 | Memory write address; bit 4 selects the table in 32x1 mode |
| wrData | input | 2 | Memory write data |
| regCe | input | 1 | Output register clock enable |
| out0 | output | 1 | First function output |
| out1 | output | 1 | Second function output |
| cascadeOut | output | 1 | Merged 5-input value for the neighbour slice |
| carryOut | output | 1 | Carry to the next slice |

## Verification
In the memory modes a write and a combinational read can target the same entry in the same cycle. The bench provokes this by holding the read index on the address it writes, with `wrEn` high. It checks before the edge that the old bit is still visible, and checks after the edge that the new bit is read. Configuration loading can also fall in a cycle with a write request. The bench holds `wrEn` high with conflicting data for the whole load and then reads back the entry to show that the loaded bit survived.

// File: rtl/slice_pkg.sv
package slice_pkg;
  localparam int MODE_W = 3;

  localparam logic [MODE_W-1:0] MODE_DUAL  = 3'd0;
  localparam logic [MODE_W-1:0] MODE_MERGE = 3'd1;
  localparam logic [MODE_W-1:0] MODE_CASC  = 3'd2;
  localparam logic [MODE_W-1:0] MODE_ADD   = 3'd3;
  localparam logic [MODE_W-1:0] MODE_RAM2  = 3'd4;
  localparam logic [MODE_W-1:0] MODE_RAM1  = 3'd5;

  // strobes from control to datapath
  typedef struct packed {
    logic shift;     // advance configuration chain
    logic blank;     // force outputs low, clear output registers
    logic wrT0;      // write table A
    logic wrT1;      // write table B
    logic wideData;  // table B takes wrData[0] (32x1 organisation)
  } sliceCtrl_t;
endpackage

// File: rtl/slice_ctrl.sv
module slice_ctrl
  import slice_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfgLoad,
  input  logic              wrEn,
  input  logic              wrTableSel,
  input  logic [MODE_W-1:0] mode,
  output sliceCtrl_t        ctl
);
  logic isRam2, isRam1, wrOk;

  assign isRam2 = (mode == MODE_RAM2);
  assign isRam1 = (mode == MODE_RAM1);
  assign wrOk   = wrEn && !cfgLoad;

  always_comb begin
    ctl          = '0;
    ctl.shift    = cfgLoad;
    ctl.blank    = cfgLoad;
    ctl.wrT0     = wrOk && (isRam2 || (isRam1 && !wrTableSel));
    ctl.wrT1     = wrOk && (isRam2 || (isRam1 &&  wrTableSel));
    ctl.wideData = isRam1;
  end

  // R2: loading locks out memory writes
  assert_load_blocks_write_R2: assert property (@(posedge clk) disable iff (rst)
    cfgLoad |-> (!ctl.wrT0 && !ctl.wrT1));

  // R8: single-bit organisation writes at most one table
  assert_ram1_one_table_R8: assert property (@(posedge clk) disable iff (rst)
    isRam1 |-> $onehot0({ctl.wrT0, ctl.wrT1}));

  // R9: logic modes never raise a write strobe
  assert_logic_mode_no_write_R9: assert property (@(posedge clk) disable iff (rst)
    (!isRam1 && !isRam2) |-> (!ctl.wrT0 && !ctl.wrT1));
endmodule

// File: rtl/slice_dp.sv
module slice_dp
  import slice_pkg::*;
#(
  parameter int LUT_IN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  sliceCtrl_t        ctl,
  input  logic              cfgBit,
  input  logic [LUT_IN-1:0] inA,
  input  logic [LUT_IN-1:0] inB,
  input  logic              sel5,
  input  logic              sel6,
  input  logic              cascadeIn,
  input  logic              carryIn,
  input  logic [LUT_IN-1:0] wrIdx,
  input  logic [1:0]        wrData,
  input  logic              regCe,
  output logic [MODE_W-1:0] mode,
  output logic              out0,
  output logic              out1,
  output logic              cascadeOut,
  output logic              carryOut
);
  localparam int DEPTH    = 1 << LUT_IN;
  localparam int TAIL_W   = MODE_W + 2;
  localparam int ADD_BITS = 2;
  localparam int NUM_OUT  = 2;

  logic [DEPTH-1:0]  tabA, tabB;
  logic [TAIL_W-1:0] tailQ;
  logic [NUM_OUT-1:0] bypass;

  assign mode   = tailQ[MODE_W-1:0];
  assign bypass = tailQ[TAIL_W-1:MODE_W];

  // configuration chain; the tables double as writable memory
  always_ff @(posedge clk) begin
    if (rst) begin
      tabA  <= '0;
      tabB  <= '0;
      tailQ <= '0;
    end else if (ctl.shift) begin
      tailQ <= {cfgBit, tailQ[TAIL_W-1:1]};
      tabB  <= {tailQ[0], tabB[DEPTH-1:1]};
      tabA  <= {tabB[0], tabA[DEPTH-1:1]};
    end else begin
      if (ctl.wrT0) tabA[wrIdx] <= wrData[0];
      if (ctl.wrT1) tabB[wrIdx] <= ctl.wideData ? wrData[0] : wrData[1];
    end
  end

  // table reads and the fifth-input merge
  logic lookA, lookBa, lookBb, merged;
  assign lookA  = tabA[inA];
  assign lookBa = tabB[inA];
  assign lookBb = tabB[inB];
  assign merged = sel5 ? lookBa : lookA;

  // dedicated ripple carry, one stage per bit
  logic [ADD_BITS:0]   carry;
  logic [ADD_BITS-1:0] sum;
  assign carry[0] = carryIn;
  for (genvar i = 0; i < ADD_BITS; i++) begin : g_carry
    logic prop;
    assign prop       = inA[i] ^ inB[i];
    assign sum[i]     = prop ^ carry[i];
    assign carry[i+1] = prop ? carry[i] : inA[i];
  end

  logic [NUM_OUT-1:0] logicVal;
  always_comb begin
    case (mode)
      MODE_MERGE: logicVal = {lookBb, merged};
      MODE_CASC:  logicVal = {lookBb, sel6 ? cascadeIn : merged};
      MODE_ADD:   logicVal = sum;
      MODE_RAM2:  logicVal = {lookBa, lookA};
      MODE_RAM1:  logicVal = {1'b0, merged};
      default:    logicVal = {lookBb, lookA};
    endcase
  end

  // per-output register with bypass
  logic [NUM_OUT-1:0] regQ, outVal;
  for (genvar k = 0; k < NUM_OUT; k++) begin : g_outreg
    always_ff @(posedge clk) begin
      if (rst || ctl.blank) regQ[k] <= 1'b0;
      else if (regCe)       regQ[k] <= logicVal[k];
    end
    assign outVal[k] = ctl.blank ? 1'b0 : (bypass[k] ? logicVal[k] : regQ[k]);
  end

  assign out0       = outVal[0];
  assign out1       = outVal[1];
  assign cascadeOut = !ctl.blank && merged;
  assign carryOut   = !ctl.blank && (mode == MODE_ADD) && carry[ADD_BITS];

  // R1: the newest serial bit enters at the top of the chain
  assert_shift_entry_R1: assert property (@(posedge clk) disable iff (rst)
    ctl.shift |=> (tailQ[TAIL_W-1] == $past(cfgBit)));

  // R9: tables only move on a shift or a write strobe
  assert_table_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!ctl.shift && !ctl.wrT0 && !ctl.wrT1) |=> ($stable(tabA) && $stable(tabB)));

  // R10: a disabled register keeps its value
  assert_reg_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!regCe && !ctl.blank) |=> $stable(regQ));

  // R6: both top operand bits set always generate a carry
  assert_carry_generate_R6: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_ADD && !ctl.blank && inA[ADD_BITS-1] && inB[ADD_BITS-1]) |-> carryOut);
endmodule

// File: rtl/logic_slice.sv
module logic_slice
  import slice_pkg::*;
#(
  parameter int LUT_IN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfgLoad,
  input  logic              cfgBit,
  input  logic [LUT_IN-1:0] inA,
  input  logic [LUT_IN-1:0] inB,
  input  logic              sel5,
  input  logic              sel6,
  input  logic              cascadeIn,
  input  logic              carryIn,
  input  logic              wrEn,
  input  logic [LUT_IN:0]   wrAddr,
  input  logic [1:0]        wrData,
  input  logic              regCe,
  output logic              out0,
  output logic              out1,
  output logic              cascadeOut,
  output logic              carryOut
);
  sliceCtrl_t        ctl;
  logic [MODE_W-1:0] mode;

  slice_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .cfgLoad    (cfgLoad),
    .wrEn       (wrEn),
    .wrTableSel (wrAddr[LUT_IN]),
    .mode       (mode),
    .ctl        (ctl)
  );

  slice_dp #(.LUT_IN(LUT_IN)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .ctl        (ctl),
    .cfgBit     (cfgBit),
    .inA        (inA),
    .inB        (inB),
    .sel5       (sel5),
    .sel6       (sel6),
    .cascadeIn  (cascadeIn),
    .carryIn    (carryIn),
    .wrIdx      (wrAddr[LUT_IN-1:0]),
    .wrData     (wrData),
    .regCe      (regCe),
    .mode       (mode),
    .out0       (out0),
    .out1       (out1),
    .cascadeOut (cascadeOut),
    .carryOut   (carryOut)
  );

  // R2: every output is quiet during a load
  assert_load_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    cfgLoad |-> (!out0 && !out1 && !cascadeOut && !carryOut));
endmodule

// File: tb/logic_slice_tb.sv
module logic_slice_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst = 1'b1;
  logic cfgBit = 1'b0, ldD = 1'b0, ldN = 1'b0;
  logic [3:0] aD = '0, bD = '0, aN = '0, bN = '0;
  logic sel5 = 1'b0, sel6 = 1'b0, cinTb = 1'b0, regCe = 1'b0;
  logic wrEn = 1'b0;
  logic [4:0] wrAddr = '0;
  logic [1:0] wrData = '0;
  logic o0D, o1D, casD, coD, o0N, o1N, casN, coN;

  int checks = 0;
  int errors = 0;

  logic_slice u_nbr (
    .clk(clk), .rst(rst), .cfgLoad(ldN), .cfgBit(cfgBit), .inA(aN), .inB(bN),
    .sel5(sel5), .sel6(sel6), .cascadeIn(1'b0), .carryIn(cinTb),
    .wrEn(1'b0), .wrAddr(5'd0), .wrData(2'd0), .regCe(regCe),
    .out0(o0N), .out1(o1N), .cascadeOut(casN), .carryOut(coN));

  logic_slice u_dut (
    .clk(clk), .rst(rst), .cfgLoad(ldD), .cfgBit(cfgBit), .inA(aD), .inB(bD),
    .sel5(sel5), .sel6(sel6), .cascadeIn(casN), .carryIn(coN),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .regCe(regCe),
    .out0(o0D), .out1(o1D), .cascadeOut(casD), .carryOut(coD));

  // bench copies of the loaded configuration
  logic [15:0] mT0, mT1, nT0, nT1;
  logic [2:0]  mMd, nMd;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // returns {carryOut, cascadeOut, out1, out0} for bypassed outputs
  function automatic logic [3:0] mdl(input logic [15:0] t0, input logic [15:0] t1,
      input logic [2:0] md, input logic [3:0] a, input logic [3:0] b,
      input logic s5, input logic s6, input logic cin, input logic cas);
    logic mg;
    logic [2:0] add;
    mg  = s5 ? t1[a] : t0[a];
    add = {1'b0, a[1:0]} + {1'b0, b[1:0]} + {2'b0, cin};
    case (md)
      3'd1:    return {1'b0, mg, t1[b], mg};
      3'd2:    return {1'b0, mg, t1[b], s6 ? cas : mg};
      3'd3:    return {add[2], mg, add[1], add[0]};
      3'd4:    return {1'b0, mg, t1[a], t0[a]};
      3'd5:    return {1'b0, mg, 1'b0, mg};
      default: return {1'b0, mg, t1[b], t0[a]};
    endcase
  endfunction

  task automatic loadCfg(input bit toDut, input logic [15:0] t0, input logic [15:0] t1,
                         input logic [2:0] md, input bit b0, input bit b1);
    logic [36:0] v;
    v = {b1, b0, md, t1, t0};
    for (int i = 0; i < 37; i++) begin
      @(negedge clk);
      if (toDut) ldD = 1'b1; else ldN = 1'b1;
      cfgBit = v[i];
      if (i == 36) begin
        #1;
        if (toDut) chk("R2 outputs quiet while loading", {4'd0, coD, casD, o1D, o0D}, 8'd0);
      end
    end
    @(negedge clk);
    ldD = 1'b0; ldN = 1'b0;
    if (toDut) begin mT0 = t0; mT1 = t1; mMd = md; end
    else begin nT0 = t0; nT1 = t1; nMd = md; end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [3:0] e, e2;
    logic [4:0] sumAct;
    logic prev;
    logic [31:0] mem32;
    void'($urandom(32'd4242));
    mT0 = '0; mT1 = '0; mMd = '0; nT0 = '0; nT1 = '0; nMd = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R11: after reset the configuration and registers are zero
    chk("R11 reset state", {4'd0, coD, casD, o1D, o0D}, 8'd0);

    // R1: load order, single marked entries
    loadCfg(1, 16'h0001, 16'h8000, 3'd0, 1, 1);
    aD = 4'd0; bD = 4'd15; #1;
    chk("R1 table A entry 0 and table B entry 15", {6'd0, o1D, o0D}, 8'h3);
    aD = 4'd1; bD = 4'd0; #1;
    chk("R1 other entries clear", {6'd0, o1D, o0D}, 8'h0);

    // R3: independent functions, mode 0 then unused code 7
    for (int pass = 0; pass < 2; pass++) begin
      loadCfg(1, 16'($urandom), 16'($urandom), pass == 0 ? 3'd0 : 3'd7, 1, 1);
      for (int i = 0; i < 16; i++) begin
        @(negedge clk);
        aD = 4'(i); bD = 4'($urandom); sel5 = 1'($urandom); #1;
        e = mdl(mT0, mT1, mMd, aD, bD, sel5, 1'b0, 1'b0, 1'b0);
        chk("R3 dual 4-input (and R6 carry low)", {4'd0, coD, casD, o1D, o0D}, {4'd0, e});
      end
    end

    // R4: merged 5-input function
    loadCfg(1, 16'($urandom), 16'($urandom), 3'd1, 1, 1);
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      aD = 4'(i); sel5 = 1'(i >> 4); bD = 4'($urandom); #1;
      e = mdl(mT0, mT1, mMd, aD, bD, sel5, 1'b0, 1'b0, 1'b0);
      chk("R4 5-input merge", {4'd0, coD, casD, o1D, o0D}, {4'd0, e});
    end

    // R5: 6-input function across two slices
    loadCfg(0, 16'($urandom), 16'($urandom), 3'd1, 1, 1);
    loadCfg(1, 16'($urandom), 16'($urandom), 3'd2, 1, 1);
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      aD = 4'(i); aN = 4'(i); sel5 = 1'(i >> 4); sel6 = 1'(i >> 5); bD = 4'($urandom); #1;
      e2 = mdl(nT0, nT1, nMd, aN, bN, sel5, 1'b0, 1'b0, 1'b0);
      e  = mdl(mT0, mT1, mMd, aD, bD, sel5, sel6, 1'b0, e2[2]);
      chk("R5 6-input cascade", {6'd0, o1D, o0D}, {6'd0, e[1:0]});
    end
    sel6 = 1'b0;

    // R6: four-bit addition over two chained slices
    loadCfg(0, 16'($urandom), 16'($urandom), 3'd3, 1, 1);
    loadCfg(1, 16'($urandom), 16'($urandom), 3'd3, 1, 1);
    for (int x = 0; x < 16; x++)
      for (int y = 0; y < 16; y++)
        for (int c = 0; c < 2; c++) begin
          @(negedge clk);
          aN = {2'b0, 2'(x)}; bN = {2'b0, 2'(y)};
          aD = {2'b0, 2'(x >> 2)}; bD = {2'b0, 2'(y >> 2)}; cinTb = 1'(c); #1;
          sumAct = {coD, o1D, o0D, o1N, o0N};
          chk("R6 chained carry add", {3'd0, sumAct}, 8'(x + y + c));
        end
    cinTb = 1'b0;

    // R7 + R2: 16x2 memory, writes held high during the load are dropped
    wrEn = 1'b1; wrAddr = 5'd0;
    mT0 = 16'($urandom); mT1 = 16'($urandom);
    wrData = {~mT1[0], ~mT0[0]};
    loadCfg(1, mT0, mT1, 3'd4, 1, 1);
    wrEn = 1'b0; aD = 4'd0; #1;
    chk("R2 write during load ignored", {6'd0, o1D, o0D}, {6'd0, mT1[0], mT0[0]});
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      aD = 4'(i); wrAddr = 5'(i); wrData = 2'($urandom); wrEn = 1'b1; #1;
      chk("R7 same-cycle read returns old", {6'd0, o1D, o0D}, {6'd0, mT1[i], mT0[i]});
      mT0[i] = wrData[0]; mT1[i] = wrData[1];
      @(negedge clk);
      wrEn = 1'b0; #1;
      chk("R7 read after write", {6'd0, o1D, o0D}, {6'd0, mT1[i], mT0[i]});
    end

    // R8: 32x1 memory
    loadCfg(1, 16'($urandom), 16'($urandom), 3'd5, 1, 1);
    mem32 = $urandom;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      wrEn = 1'b1; wrAddr = 5'(i); wrData = {1'($urandom), mem32[i]};
    end
    @(negedge clk);
    wrEn = 1'b0;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      aD = 4'(i); sel5 = 1'(i >> 4); #1;
      chk("R8 32x1 read", {6'd0, o1D, o0D}, {7'd0, mem32[i]});
    end
    sel5 = 1'b0;

    // R9: writes in a logic mode leave the tables intact (R11 reload)
    loadCfg(1, 16'($urandom), 16'($urandom), 3'd0, 1, 1);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      wrEn = 1'b1; wrAddr = 5'(i); wrData = {~mT1[i], ~mT0[i]};
    end
    @(negedge clk);
    wrEn = 1'b0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      aD = 4'(i); bD = 4'(i); #1;
      chk("R9 write ignored in logic mode", {6'd0, o1D, o0D}, {6'd0, mT1[i], mT0[i]});
    end

    // R10: out0 registered, out1 bypassed
    regCe = 1'b0;
    loadCfg(1, 16'($urandom), 16'($urandom), 3'd0, 0, 1);
    prev = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      aD = 4'($urandom); bD = 4'($urandom); regCe = 1'b1; #1;
      chk("R10 registered output before edge", {7'd0, o0D}, {7'd0, prev});
      chk("R10 bypassed output same cycle", {7'd0, o1D}, {7'd0, mT1[bD]});
      @(posedge clk); #1;
      chk("R10 registered output after edge", {7'd0, o0D}, {7'd0, mT0[aD]});
      prev = mT0[aD];
    end
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      regCe = 1'b0; aD = 4'($urandom);
      @(posedge clk); #1;
      chk("R10 hold with enable low", {7'd0, o0D}, {7'd0, prev});
    end

    // R11: reset clears configuration and registers
    loadCfg(1, 16'hFFFF, 16'hFFFF, 3'd0, 1, 1);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; regCe = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      aD = 4'($urandom); bD = 4'($urandom); #1;
      chk("R11 outputs zero after reset", {4'd0, coD, casD, o1D, o0D}, 8'd0);
    end

    finish_run();
  end
endmodule